// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block keeps the index bookkeeping for a pair of circular descriptor rings: one for transmit, one for receive. Each ring has a size register and two indices. Software owns the transmit produce index and the receive consume index. The block's hardware side owns the transmit consume index and the receive produce index, and advances them on frame-completion strobes. From these indices the block derives full and empty flags and a two-bit engine activity word.

Every received frame that the block accepts makes it emit a one-cycle write-back of a 32-bit status word. The word carries the descriptor slot it belongs to, the frame length minus one, and the error flags. A receive completion that arrives while the ring is full does not move the produce index. It sets a sticky overrun flag instead. Data movement, bus mastering and the MAC itself sit outside this block.

Top module: `dring_idx_mgr`

## Requirements
- R1: After reset, all four indices are 0, both size registers hold the entry count minus one given by the reset parameter (3, which means 4 entries), both rings report empty, the transmit ring reports not full, the receive ring reports not full, overrun is 0 and wb_valid is 0.
- R2: A size write stores `sw_wdata` as the entry count minus one. It clears both indices of that ring to 0, and a receive size write also clears overrun. All of this is visible on the next cycle.
- R3: A software index write (`tx_prod_we` or `rx_cons_we`) stores `sw_wdata` on the next cycle. If the value is above that ring's stored size, 0 is stored instead.
- R4: Every index advance wraps from the stored size value to 0.
- R5: For each ring, empty means produce equals consume, and full means (produce+1 modulo count) equals consume. At most count-1 entries can therefore be outstanding. A ring of one entry is both full and empty.
- R6: `tx_done` advances the transmit consume index by one when the transmit ring is not empty. When the ring is empty it leaves every output unchanged.
- R7: `rx_done` advances the receive produce index when the receive ring is not full. When the ring is full, the index stays put and `rx_overrun` is set. `rx_overrun` then holds until a receive consume write or a receive size write clears it. A set in the same cycle as a clear wins.
- R8: One cycle after an accepted `rx_done`, `wb_valid` is 1 for that cycle and `wb_idx` is the produce index before the advance. `wb_word[10:0]` is `rx_len_m1`, `wb_word[28:23]` is `rx_flags[5:0]`, and bit 26 (`rx_flags[3]`) is the range flag. `wb_word[31]` is the OR of bits 23, 24, 25, 27 and 28, with the range flag left out. All other bits are 0.
- R9: `eng_stat[1]` is 1 while the transmit ring is not empty. `eng_stat[0]` is 1 while the receive ring is not full.
- R10: A size write beats a same-cycle index write and a same-cycle completion strobe on that ring. The strobe is dropped, with no advance, no write-back and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_size_we | input | 1 | Write transmit ring size (count minus one) |
| rx_size_we | input | 1 | Write receive ring size (count minus one) |
| tx_prod_we | input | 1 | Software write of transmit produce index |
| rx_cons_we | input | 1 | Software write of receive consume index |
| sw_wdata | input | IDX_W | Data for all software writes |
| tx_done | input | 1 | A transmit descriptor finished |
| rx_done | input | 1 | A receive frame finished |
| rx_len_m1 | input | 11 | Received length minus one |
| rx_flags | input | 6 | Receive error flags; bit 3 is the range flag |
| tx_size_m1 | output | IDX_W | Stored transmit size |
| rx_size_m1 | output | IDX_W | Stored receive size |
| tx_prod | output | IDX_W | Transmit produce index |
| tx_cons | output | IDX_W | Transmit consume index |
| rx_prod | output | IDX_W | Receive produce index |
| rx_cons | output | IDX_W | Receive consume index |
| tx_full | output | 1 | Transmit ring full |
| tx_empty | output | 1 | Transmit ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_empty | output | 1 | Receive ring empty |
| rx_overrun | output | 1 | Sticky receive overrun |
| eng_stat | output | 2 | Bit 1 transmit active, bit 0 receive active |
| wb_valid | output | 1 | Status write-back strobe |
| wb_idx | output | IDX_W | Slot the write-back belongs to |
| wb_word | output | 32 | Status word being written back |

## Verification
Every register, index and sticky flag responds one clock edge after the strobe or write that moves it. The full, empty and engine bits are combinational on those registers, so they follow in the same cycle as the index. The write-back strobe and word appear one edge after the accepted `rx_done`, and only for that cycle.

The bench drives inputs on the falling edge. Its reference model updates on the rising edge from the inputs held across it. All outputs are compared with the model on the next falling edge, so each result is read exactly one edge after its cause. The directed checks read the outputs at that same falling edge, right after the strobe is dropped.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int LEN_W    = 11;
  localparam int FLAG_W   = 6;
  localparam int FLAG_LSB = 23;
  localparam int SUM_BIT  = 31;
  localparam logic [FLAG_W-1:0] SUM_MASK = 6'b110111;  // range flag (bit 3) excluded

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len_m1,
                                              input logic [FLAG_W-1:0] flags);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len_m1;
    w[FLAG_LSB +: FLAG_W] = flags;
    w[SUM_BIT] = |(flags & SUM_MASK);
    return w;
  endfunction
endpackage

// File: rtl/dr_ring.sv
module dr_ring #(
  parameter int IDX_W      = 4,
  parameter int RST_M1     = 3,
  parameter bit HW_IS_PROD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             size_we,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] wdata,
  input  logic             hw_ev,
  output logic [IDX_W-1:0] size_m1,
  output logic [IDX_W-1:0] prod,
  output logic [IDX_W-1:0] cons,
  output logic             full,
  output logic             empty,
  output logic             hw_fire
);
  localparam logic [IDX_W-1:0] RST_SIZE = IDX_W'(RST_M1);

  logic [IDX_W-1:0] size_q, size_d, sw_q, sw_d, hw_q, hw_d;
  logic             size_en, sw_en, hw_en, allow, blocked;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v,
                                                input logic [IDX_W-1:0] lim);
    return (v == lim) ? '0 : v + 1'b1;
  endfunction

  generate
    if (HW_IS_PROD) begin : g_hw_prod
      assign prod  = hw_q;
      assign cons  = sw_q;
      assign allow = ~full;
    end else begin : g_hw_cons
      assign prod  = sw_q;
      assign cons  = hw_q;
      assign allow = ~empty;
    end
  endgenerate

  assign full    = (wrap_inc(prod, size_q) == cons);
  assign empty   = (prod == cons);
  assign hw_fire = hw_ev & allow & ~size_we;
  assign blocked = hw_ev & ~allow & ~size_we;
  assign size_m1 = size_q;

  always_comb begin
    size_d  = size_q;
    sw_d    = sw_q;
    hw_d    = hw_q;
    size_en = size_we;
    sw_en   = size_we | sw_we;
    hw_en   = size_we | hw_fire;
    if (size_we) begin
      size_d = wdata;
      sw_d   = '0;
      hw_d   = '0;
    end else begin
      if (sw_we)   sw_d = (wdata > size_q) ? '0 : wdata;
      if (hw_fire) hw_d = wrap_inc(hw_q, size_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= RST_SIZE;
      sw_q   <= '0;
      hw_q   <= '0;
    end else begin
      if (size_en) size_q <= size_d;
      if (sw_en)   sw_q   <= sw_d;
      if (hw_en)   hw_q   <= hw_d;
    end
  end

  // R3: indices never exceed the stored size
  p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q <= size_q) && (hw_q <= size_q));
  // R2: size write clears both indices
  p_size_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> (sw_q == '0) && (hw_q == '0));
  // R4: an accepted step wraps at the size value
  p_hw_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fire && (hw_q == size_q)) |=> (hw_q == '0));
  // R6 / R7: a refused strobe leaves the hardware index alone
  p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(hw_q));
endmodule

// File: rtl/dr_rx_status.sv
module dr_rx_status
  import dr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             rx_done,
  input  logic             rx_full,
  input  logic             size_we,
  input  logic             cons_we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [FLAG_W-1:0] flags,
  output logic             overrun,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [31:0]      wb_word
);
  logic             ovr_q, ovr_d, ovr_set, ovr_clr;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      word_q;

  assign ovr_set = rx_done & rx_full & ~size_we;
  assign ovr_clr = size_we | cons_we;

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      ovr_q <= ovr_d;
      vld_q <= fire;
      if (fire) begin
        idx_q  <= wr_idx;
        word_q <= pack_status(len_m1, flags);
      end
    end
  end

  assign overrun  = ovr_q;
  assign wb_valid = vld_q;
  assign wb_idx   = idx_q;
  assign wb_word  = word_q;

  // R7: overrun only rises after a strobe against a full ring
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_done && rx_full));
  // R8: a write-back only follows a receive strobe
  p_wb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(rx_done));
  // R10: a size write suppresses the write-back
  p_size_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> !vld_q);
endmodule

// File: rtl/dring_idx_mgr.sv
module dring_idx_mgr
  import dr_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int TX_RST_M1 = 3,
  parameter int RX_RST_M1 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_size_we,
  input  logic              rx_size_we,
  input  logic              tx_prod_we,
  input  logic              rx_cons_we,
  input  logic [IDX_W-1:0]  sw_wdata,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len_m1,
  input  logic [FLAG_W-1:0] rx_flags,
  output logic [IDX_W-1:0]  tx_size_m1,
  output logic [IDX_W-1:0]  rx_size_m1,
  output logic [IDX_W-1:0]  tx_prod,
  output logic [IDX_W-1:0]  tx_cons,
  output logic [IDX_W-1:0]  rx_prod,
  output logic [IDX_W-1:0]  rx_cons,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_overrun,
  output logic [1:0]        eng_stat,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [31:0]       wb_word
);
  logic tx_fire, rx_fire;

  dr_ring #(.IDX_W(IDX_W), .RST_M1(TX_RST_M1), .HW_IS_PROD(1'b0)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .size_we(tx_size_we), .sw_we(tx_prod_we),
    .wdata(sw_wdata), .hw_ev(tx_done), .size_m1(tx_size_m1), .prod(tx_prod),
    .cons(tx_cons), .full(tx_full), .empty(tx_empty), .hw_fire(tx_fire));

  dr_ring #(.IDX_W(IDX_W), .RST_M1(RX_RST_M1), .HW_IS_PROD(1'b1)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .size_we(rx_size_we), .sw_we(rx_cons_we),
    .wdata(sw_wdata), .hw_ev(rx_done), .size_m1(rx_size_m1), .prod(rx_prod),
    .cons(rx_cons), .full(rx_full), .empty(rx_empty), .hw_fire(rx_fire));

  dr_rx_status #(.IDX_W(IDX_W)) u_rx_stat (
    .clk(clk), .rst_n(rst_n), .fire(rx_fire), .rx_done(rx_done),
    .rx_full(rx_full), .size_we(rx_size_we), .cons_we(rx_cons_we),
    .wr_idx(rx_prod), .len_m1(rx_len_m1), .flags(rx_flags),
    .overrun(rx_overrun), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_word(wb_word));

  assign eng_stat = {~tx_empty, ~rx_full};

  // R6: the transmit consume index never passes the produce index
  p_tx_no_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_empty && !tx_size_we) |=> (tx_cons == $past(tx_cons)));
  // R9: transmit engine bit tracks outstanding work
  p_eng_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stat[1] == (tx_prod != tx_cons));
endmodule

// File: tb/dring_idx_mgr_tb.sv
module dring_idx_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;
  localparam int WDOG       = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_size_we, rx_size_we, tx_prod_we, rx_cons_we, tx_done, rx_done;
  logic [IDX_W-1:0] sw_wdata;
  logic [10:0] rx_len_m1;
  logic [5:0]  rx_flags;
  logic [IDX_W-1:0] tx_size_m1, rx_size_m1, tx_prod, tx_cons, rx_prod, rx_cons, wb_idx;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_overrun, wb_valid;
  logic [1:0]  eng_stat;
  logic [31:0] wb_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_ts, m_rs, m_tp, m_tc, m_rp, m_rc, m_wbi;
  bit m_ovr, m_wbv;
  logic [31:0] m_wbw;

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_idx_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .tx_size_we(tx_size_we), .rx_size_we(rx_size_we),
    .tx_prod_we(tx_prod_we), .rx_cons_we(rx_cons_we), .sw_wdata(sw_wdata),
    .tx_done(tx_done), .rx_done(rx_done), .rx_len_m1(rx_len_m1), .rx_flags(rx_flags),
    .tx_size_m1(tx_size_m1), .rx_size_m1(rx_size_m1), .tx_prod(tx_prod),
    .tx_cons(tx_cons), .rx_prod(rx_prod), .rx_cons(rx_cons), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun), .eng_stat(eng_stat), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_word(wb_word));

  function automatic int nxt(input int v, input int lim);
    return (v == lim) ? 0 : v + 1;
  endfunction

  function automatic logic [31:0] exp_word(input int len, input logic [5:0] f);
    logic [31:0] w;
    w = 32'(len) | (32'(f) << 23);
    if (f[0] | f[1] | f[2] | f[4] | f[5]) w[31] = 1'b1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // model update on the rising edge from held inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ts = 3; m_rs = 3; m_tp = 0; m_tc = 0; m_rp = 0; m_rc = 0;
      m_ovr = 0; m_wbv = 0; m_wbi = 0; m_wbw = '0;
    end else begin
      bit t_empty, r_full;
      t_empty = (m_tp == m_tc);
      r_full  = (nxt(m_rp, m_rs) == m_rc);
      m_wbv = 0;
      if (tx_size_we) begin
        m_ts = int'(sw_wdata); m_tp = 0; m_tc = 0;
      end else begin
        if (tx_prod_we) m_tp = (int'(sw_wdata) > m_ts) ? 0 : int'(sw_wdata);
        if (tx_done && !t_empty) m_tc = nxt(m_tc, m_ts);
      end
      if (rx_size_we) begin
        m_rs = int'(sw_wdata); m_rp = 0; m_rc = 0; m_ovr = 0;
      end else begin
        if (rx_cons_we) begin
          m_rc = (int'(sw_wdata) > m_rs) ? 0 : int'(sw_wdata);
          m_ovr = 0;
        end
        if (rx_done) begin
          if (!r_full) begin
            m_wbv = 1; m_wbi = m_rp; m_wbw = exp_word(int'(rx_len_m1), rx_flags);
            m_rp = nxt(m_rp, m_rs);
          end else begin
            m_ovr = 1;
          end
        end
      end
      started = 1'b1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      chk(int'(tx_size_m1) == m_ts && int'(rx_size_m1) == m_rs, "R2", "sizes",
          {tx_size_m1, rx_size_m1}, {m_ts[3:0], m_rs[3:0]});
      chk(int'(tx_prod) == m_tp && int'(rx_cons) == m_rc, "R3 R10", "sw idx",
          {tx_prod, rx_cons}, {m_tp[3:0], m_rc[3:0]});
      chk(int'(tx_cons) == m_tc && int'(rx_prod) == m_rp, "R4 R6 R7", "hw idx",
          {tx_cons, rx_prod}, {m_tc[3:0], m_rp[3:0]});
      chk(tx_empty == (m_tp == m_tc) && tx_full == (nxt(m_tp, m_ts) == m_tc) &&
          rx_empty == (m_rp == m_rc) && rx_full == (nxt(m_rp, m_rs) == m_rc),
          "R5", "flags", {tx_full, tx_empty, rx_full, rx_empty},
          {nxt(m_tp, m_ts) == m_tc, m_tp == m_tc, nxt(m_rp, m_rs) == m_rc, m_rp == m_rc});
      chk(rx_overrun == m_ovr, "R7", "overrun", rx_overrun, m_ovr);
      chk(eng_stat == {m_tp != m_tc, nxt(m_rp, m_rs) != m_rc}, "R9", "eng_stat",
          eng_stat, {m_tp != m_tc, nxt(m_rp, m_rs) != m_rc});
      chk(wb_valid == m_wbv, "R8", "wb_valid", wb_valid, m_wbv);
      if (m_wbv)
        chk(int'(wb_idx) == m_wbi && wb_word == m_wbw, "R8", "wb idx/word",
            {wb_idx, wb_word}, {m_wbi[3:0], m_wbw});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    tx_size_we = 0; rx_size_we = 0; tx_prod_we = 0; rx_cons_we = 0;
    tx_done = 0; rx_done = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    sw_wdata = '0; rx_len_m1 = '0; rx_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_prod == 0 && tx_cons == 0 && rx_prod == 0 && rx_cons == 0, "R1", "indices",
        {tx_prod, tx_cons, rx_prod, rx_cons}, 0);
    chk(tx_size_m1 == 3 && rx_size_m1 == 3, "R1", "sizes", {tx_size_m1, rx_size_m1}, 8'h33);
    chk(tx_empty && rx_empty && !tx_full && !rx_full && !rx_overrun && !wb_valid, "R1",
        "flags", {tx_empty, rx_empty, tx_full, rx_full, rx_overrun, wb_valid}, 6'b110000);

    // R5 transmit fills at count-1
    tx_prod_we = 1; sw_wdata = 3; tick();
    chk(tx_full && tx_prod == 3, "R5", "tx full", {tx_full, tx_prod}, {1'b1, 4'd3});
    chk(eng_stat[1] == 1'b1, "R9", "tx active", eng_stat[1], 1);

    // R6 drain, then one extra strobe is ignored
    for (int i = 0; i < 3; i++) begin tx_done = 1; tick(); end
    chk(tx_empty && tx_cons == 3, "R6", "tx drained", {tx_empty, tx_cons}, {1'b1, 4'd3});
    tx_done = 1; tick();
    chk(tx_cons == 3 && tx_empty, "R6", "empty strobe ignored", tx_cons, 3);

    // R4 wrap of transmit consume
    tx_prod_we = 1; sw_wdata = 1; tick();
    tx_done = 1; tick();
    chk(tx_cons == 0, "R4", "tx wrap", tx_cons, 0);
    tx_done = 1; tick();

    // R7 receive fills, fourth frame overruns
    for (int i = 0; i < 3; i++) begin
      rx_done = 1; rx_len_m1 = 11'(100 + i); rx_flags = 6'(i); tick();
    end
    chk(rx_full && rx_prod == 3, "R7", "rx full", {rx_full, rx_prod}, {1'b1, 4'd3});
    rx_done = 1; tick();
    chk(rx_overrun && rx_prod == 3 && !wb_valid, "R7", "overrun",
        {rx_overrun, rx_prod, wb_valid}, {1'b1, 4'd3, 1'b0});

    // R3 clamp of out-of-range consume write, clears overrun
    rx_cons_we = 1; sw_wdata = 9; tick();
    chk(rx_cons == 0 && !rx_overrun, "R3", "clamp", {rx_cons, rx_overrun}, 0);

    // R10 size write wins over a same-cycle frame
    rx_cons_we = 1; sw_wdata = 2; tick();
    rx_size_we = 1; rx_done = 1; sw_wdata = 7; tick();
    chk(rx_size_m1 == 7 && rx_prod == 0 && rx_cons == 0 && !wb_valid, "R10", "priority",
        {rx_size_m1, rx_prod, rx_cons, wb_valid}, {4'd7, 4'd0, 4'd0, 1'b0});

    // R8 range flag excluded from the summary bit
    rx_done = 1; rx_len_m1 = 11'h5EA; rx_flags = 6'b001000; tick();
    chk(wb_valid && wb_word == 32'h040005EA && wb_idx == 0, "R8", "range only",
        wb_word, 32'h040005EA);
    rx_done = 1; rx_len_m1 = 11'h03F; rx_flags = 6'b000001; tick();
    chk(wb_valid && wb_word == 32'h8080003F && wb_idx == 1, "R8", "crc-type error",
        wb_word, 32'h8080003F);

    // R5 one-entry ring is full and empty at once
    tx_size_we = 1; sw_wdata = 0; tick();
    chk(tx_full && tx_empty, "R5", "one entry", {tx_full, tx_empty}, 2'b11);
    tx_size_we = 1; sw_wdata = 3; tick();

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      sw_wdata   = r[3:0];
      tx_size_we = (r[11:6] == 0);
      rx_size_we = (r[17:12] == 0);
      tx_prod_we = r[18] & r[19];
      rx_cons_we = r[20] & r[21];
      tx_done    = r[22];
      rx_done    = r[23];
      rx_len_m1  = 11'($urandom);
      rx_flags   = 6'($urandom);
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule